// File: doc/BRIEF.md
# Serial Audio Transmit Channel with Underrun Hold

This block feeds one serial audio data line. It draws 32-bit words from a transmit FIFO through a valid/ready pop interface and splits each word into samples. A 2-bit width code sets the sample size to 8, 16 or 32 bits, and a mono flag picks mono or stereo. The block runs on a single system clock. A one-cycle bit strobe marks each bit-clock edge on which serial data changes, and a word-select level picks the channel: low is left, high is right.

Samples are sent MSB first and left-aligned in their channel slot. A change in word select, seen on a strobe, loads a new sample. After a word-select fall the block builds the pair for the next frame. If the FIFO has no data in time, the previous pair is sent again rather than silence. The stop input mutes the line and freezes all FIFO traffic. A synchronous channel reset input clears the held data and the unpack position, and must be pulsed after any change of width or mode.

Top module: `i2s_tx_serializer`

## Requirements
- R1: Width code 0 packs four 8-bit samples per word, code 1 packs two 16-bit samples, and code 3 packs one 32-bit sample. Code 2 behaves exactly like code 3.
- R2: In stereo mode with 8 or 16 bits, a pair comes from a single word. The lower byte or halfword (bits [7:0] or [15:0] first) is left and the next higher one is right. With 32-bit stereo a pair takes two words: the first is left and the second is right.
- R3: In mono mode each sample is sent on both channels. Samples within a word are used from the lowest position upward, one per frame.
- R4: Each slot carries its sample MSB first, starting at the strobe where the word-select change is seen. After the sample's width the line is 0 for the rest of the slot.
- R5: A word-select fall (1 to 0 on a strobe) loads the left sample of the pending pair. The next rise (0 to 1) loads the right sample of that same pair.
- R6: After reset, after a channel reset, and after each word-select fall, the block assembles one new pair. fifo_ready is high only while a word is needed and the internal word buffer is empty.
- R7: If no new pair is complete by the next word-select fall, the previous pair is sent again, unchanged and not muted.
- R8: While stop is 1, sd_out is 0 and no FIFO word is popped. Bit shifting and word-select tracking continue.
- R9: A channel reset clears the shift register, the pending and held pair, the buffered word and the unpack position. Until new data arrives the line then sends zeros.
- R10: After rst_n is released, sd_out is 0 and fifo_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset (resync after width/mode change) |
| stop | input | 1 | Mute output and freeze FIFO fetches |
| width_code | input | 2 | Sample width: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| mono | input | 1 | 1 = mono (same sample both channels), 0 = stereo |
| bit_stb | input | 1 | One-cycle strobe at each bit-clock data edge |
| ws | input | 1 | Word-select level, 0 = left, 1 = right |
| fifo_data | input | 32 | FIFO head word |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_ready | output | 1 | Block pops the head word this cycle when valid |
| sd_out | output | 1 | Serial data |

## Verification
The hardest situation to reach from the ports is an underrun that falls in the middle of the word sequence. In that case a frame boundary arrives while the FIFO is empty, and the pair already sent must come out again bit for bit; after that, late-arriving words must resume exactly in packing order. The bench reaches this by giving the FIFO fewer pairs than the number of frames it plays, then refilling it between frames. The scoreboard expects the last pair whenever its queue is empty. Stop is raised with a non-zero held pair and a word waiting in the FIFO, so that muting can be told apart from repeating and from popping.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_rst,
  input  logic        stop,
  input  logic [1:0]  width_code,
  input  logic        mono,
  input  logic        bit_stb,
  input  logic        ws,
  input  logic [31:0] fifo_data,
  input  logic        fifo_valid,
  output logic        fifo_ready,
  output logic        sd_out
);

  logic [31:0] sh, pend_l, pend_r, right_q, wbuf, left_part;
  logic        wbuf_ok, got_left, want, ws_q;
  logic [1:0]  pos;

  logic [31:0] smp_l, smp_r;
  logic        last, extract, commit;
  logic [1:0]  step;

  wire ws_fall = bit_stb & ws_q & ~ws;
  wire ws_rise = bit_stb & ~ws_q & ws;
  wire is8     = (width_code == 2'd0);
  wire is16    = (width_code == 2'd1);
  wire is32    = width_code[1];
  wire pair32  = is32 & ~mono;

  wire [1:0]  pos_nx = pos + 2'd1;
  wire [7:0]  byte_a = wbuf[{pos, 3'b000} +: 8];
  wire [7:0]  byte_b = wbuf[{pos_nx, 3'b000} +: 8];
  wire [15:0] half_a = wbuf[{pos[0], 4'b0000} +: 16];

  always_comb begin
    smp_l = wbuf;
    smp_r = wbuf;
    last  = 1'b1;
    step  = mono ? 2'd1 : 2'd2;
    if (is8) begin
      smp_l = {byte_a, 24'h0};
      smp_r = mono ? {byte_a, 24'h0} : {byte_b, 24'h0};
      last  = mono ? (pos == 2'd3) : pos[1];
    end else if (is16) begin
      smp_l = mono ? {half_a, 16'h0} : {wbuf[15:0], 16'h0};
      smp_r = mono ? {half_a, 16'h0} : {wbuf[31:16], 16'h0};
      last  = mono ? pos[0] : 1'b1;
    end else if (pair32) begin
      smp_l = left_part;
    end
  end

  assign extract    = want & ~stop & wbuf_ok;
  assign commit     = extract & ~(pair32 & ~got_left);
  assign fifo_ready = want & ~stop & ~wbuf_ok;
  assign sd_out     = ~stop & sh[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; pend_l <= '0; pend_r <= '0; right_q <= '0;
      wbuf <= '0; left_part <= '0; wbuf_ok <= 1'b0; got_left <= 1'b0;
      want <= 1'b1; ws_q <= 1'b1; pos <= '0;
    end else if (chan_rst) begin
      sh <= '0; pend_l <= '0; pend_r <= '0; right_q <= '0;
      wbuf <= '0; left_part <= '0; wbuf_ok <= 1'b0; got_left <= 1'b0;
      want <= 1'b1; ws_q <= 1'b1; pos <= '0;
    end else begin
      if (bit_stb) begin
        ws_q <= ws;
        if (ws_fall) begin
          sh      <= pend_l;
          right_q <= pend_r;
        end else if (ws_rise) begin
          sh <= right_q;
        end else begin
          sh <= {sh[30:0], 1'b0};
        end
      end
      if (fifo_ready && fifo_valid) begin
        wbuf    <= fifo_data;
        wbuf_ok <= 1'b1;
      end
      if (extract) begin
        if (pair32 && !got_left) begin
          left_part <= wbuf;
          got_left  <= 1'b1;
          wbuf_ok   <= 1'b0;
        end else begin
          pend_l   <= smp_l;
          pend_r   <= smp_r;
          got_left <= 1'b0;
          if (last) begin
            wbuf_ok <= 1'b0;
            pos     <= '0;
          end else begin
            pos <= pos + step;
          end
        end
      end
      want <= commit ? 1'b0 : (ws_fall ? 1'b1 : want);
    end
  end

  AST_LEFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && ws_q && !ws && !chan_rst) |=> (sh == $past(pend_l))); // R5
  AST_RIGHT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !ws_q && ws && !chan_rst) |=> (sh == $past(right_q))); // R5
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && (ws == ws_q) && !chan_rst) |=> (sh[0] == 1'b0)); // R4
  AST_POP_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && fifo_valid && !chan_rst) |=> wbuf_ok); // R6
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !chan_rst) |=> ($stable(wbuf_ok) && $stable(pend_l) && $stable(pend_r))); // R8
  AST_CHRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (sh == 32'h0 && pend_l == 32'h0 && pend_r == 32'h0 && !wbuf_ok && pos == 2'd0)); // R9

endmodule

// File: tb/test_i2s_tx_serializer.sv
module test_i2s_tx_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, chan_rst = 1'b0, stop = 1'b0, mono = 1'b0;
  logic [1:0]  width_code = 2'd3;
  logic        bit_stb = 1'b0, ws = 1'b1;
  logic [31:0] fifo_data = '0;
  logic        fifo_valid = 1'b0;
  logic        fifo_ready, sd_out;

  always #10 clk = ~clk;

  i2s_tx_serializer i_i2s_tx_serializer (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .stop(stop),
    .width_code(width_code), .mono(mono), .bit_stb(bit_stb), .ws(ws),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .sd_out(sd_out));

  int n_tests = 0, n_fail = 0;
  logic [31:0] fq[$];
  logic [31:0] exp_l[$], exp_r[$];
  logic [31:0] last_l = '0, last_r = '0;
  logic        take = 1'b0;

  // FIFO model: the handshake is sampled mid-cycle and the word removed one cycle later
  always @(negedge clk) begin
    if (take) void'(fq.pop_front());
    fifo_valid = (fq.size() > 0);
    fifo_data  = (fq.size() > 0) ? fq[0] : 32'h0;
    take = fifo_ready && fifo_valid;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic feed(input logic [31:0] w);
    fq.push_back(w);
  endtask

  task automatic expect_pair(input logic [31:0] l, input logic [31:0] r);
    exp_l.push_back(l);
    exp_r.push_back(r);
  endtask

  task automatic set_mode(input logic [1:0] code, input logic m);
    width_code = code;
    mono = m;
    chan_rst = 1'b1;
    @(negedge clk);
    chan_rst = 1'b0;
    last_l = '0;
    last_r = '0;
  endtask

  // generator and monitor: plays frames and compares each slot with the scoreboard
  task automatic play(input int n, input string tag, input bit muted);
    for (int f = 0; f < n; f++) begin
      logic [31:0] got_l, got_r, xl, xr;
      got_l = '0;
      got_r = '0;
      repeat (8) @(negedge clk);
      for (int b = 0; b < 64; b++) begin
        bit_stb = 1'b1;
        ws = (b >= 32);
        @(negedge clk);
        bit_stb = 1'b0;
        if (b < 32) got_l = {got_l[30:0], sd_out};
        else        got_r = {got_r[30:0], sd_out};
        @(negedge clk);
      end
      if (muted) begin
        xl = '0; xr = '0;
      end else if (exp_l.size() > 0) begin
        xl = exp_l.pop_front(); xr = exp_r.pop_front();
        last_l = xl; last_r = xr;
      end else begin
        xl = last_l; xr = last_r;
      end
      chk({tag, " left"}, got_l, xl);
      chk({tag, " right"}, got_r, xr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired got %0d exp %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 sd_out after reset", {31'h0, sd_out}, 32'h0);
    chk("R10 fifo_ready after reset", {31'h0, fifo_ready}, 32'h1);

    // R1 R2 R5: 32-bit stereo, two words per pair; then R7 underrun repeat
    set_mode(2'd3, 1'b0);
    feed(32'h8123_4567); feed(32'h0FED_CBA9); feed(32'hA5A5_0001); feed(32'h5A5A_8000);
    expect_pair(32'h8123_4567, 32'h0FED_CBA9);
    expect_pair(32'hA5A5_0001, 32'h5A5A_8000);
    play(4, "R2 R5 R7 stereo32", 1'b0);
    feed(32'h1111_2222); feed(32'h3333_4444);
    expect_pair(32'h1111_2222, 32'h3333_4444);
    play(2, "R7 R6 resume stereo32", 1'b0);

    // R1 R2 R4: 16-bit stereo, low half left, zero fill
    set_mode(2'd1, 1'b0);
    feed(32'hBEEF_1234); feed(32'h0F0F_A5A5);
    expect_pair(32'h1234_0000, 32'hBEEF_0000);
    expect_pair(32'hA5A5_0000, 32'h0F0F_0000);
    play(3, "R1 R2 R4 stereo16", 1'b0);

    // R3: 16-bit mono
    set_mode(2'd1, 1'b1);
    feed(32'hCAFE_0081);
    expect_pair(32'h0081_0000, 32'h0081_0000);
    expect_pair(32'hCAFE_0000, 32'hCAFE_0000);
    play(2, "R3 mono16", 1'b0);

    // R1 R2: 8-bit stereo, two pairs per word
    set_mode(2'd0, 1'b0);
    feed(32'h4433_2211); feed(32'h8877_6655);
    expect_pair(32'h1100_0000, 32'h2200_0000);
    expect_pair(32'h3300_0000, 32'h4400_0000);
    expect_pair(32'h5500_0000, 32'h6600_0000);
    expect_pair(32'h7700_0000, 32'h8800_0000);
    play(5, "R1 R2 R7 stereo8", 1'b0);

    // R3: 8-bit mono, four frames per word
    set_mode(2'd0, 1'b1);
    feed(32'hD4C3_B2A1);
    expect_pair(32'hA100_0000, 32'hA100_0000);
    expect_pair(32'hB200_0000, 32'hB200_0000);
    expect_pair(32'hC300_0000, 32'hC300_0000);
    expect_pair(32'hD400_0000, 32'hD400_0000);
    play(4, "R3 mono8", 1'b0);

    // R8: stop mutes a non-zero held pair and leaves the FIFO untouched
    stop = 1'b1;
    feed(32'h0403_0201);
    play(1, "R8 stop mute", 1'b1);
    chk("R8 no pop while stopped", fq.size(), 32'd1);
    stop = 1'b0;
    expect_pair(32'h0100_0000, 32'h0100_0000);
    expect_pair(32'h0200_0000, 32'h0200_0000);
    expect_pair(32'h0300_0000, 32'h0300_0000);
    expect_pair(32'h0400_0000, 32'h0400_0000);
    play(4, "R8 R3 after stop", 1'b0);

    // R1: code 2 behaves as 32-bit
    set_mode(2'd2, 1'b0);
    feed(32'hF00D_0001); feed(32'h0002_D00F);
    expect_pair(32'hF00D_0001, 32'h0002_D00F);
    play(2, "R1 code2 as 32-bit", 1'b0);

    // R9: channel reset clears the held pair; an empty FIFO then gives zeros
    set_mode(2'd2, 1'b0);
    chk("R9 fifo_ready after chan reset", {31'h0, fifo_ready}, 32'h1);
    play(1, "R9 cleared hold", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule